// File: doc/BRIEF.md
# Machine-Mode Control and Status Register Bank

This block holds the control and status registers of a single-hart 64-bit core that runs only at the highest privilege level. The core's execute stage reaches it through one access port: a 12-bit register address, a 2-bit operation (read, write, bit-set or bit-clear) and 64-bit write data. Read data comes back in the same cycle. An address that selects no register raises an illegal flag in that same cycle, so that the core can raise an illegal-instruction exception (cause code 2).

The trap logic of the core drives a trap-entry strobe with a cause code, an interrupt flag and the PC to save. A return strobe restores the interrupt enable. The bank gives the handler address and the saved PC back to the fetch logic. It turns the single external interrupt line into an interrupt request. It also keeps a free-running clock-cycle counter and a fetch counter.

The reset input is asynchronous and active-low. It must already be released in step with the clock before it reaches the bank.

Top module: `mcsr_bank`

## Requirements
- R1: After reset, the trap vector reads 0xFFFF_FFFF_FFFF_FE00 and the status register reads 0x0000_0000_0000_1D00. Scratch, exception PC, cause, bad-address, interrupt-enable and both counters read 0, and `trap_vector` shows the vector value.
- R2: `csr_op` encodes 0 = read only, 1 = write, 2 = set the bits that are one in the write data, and 3 = clear them. The new value is taken at the clock edge. Scratch (0x340), trap vector (0x305), exception PC (0x341) and bad address (0x343) are fully writable.
- R3: Writes, sets and clears leave read-only bits unchanged and raise no flag. The ISA register (0x301) always reads 0x8000_0000_0004_0100 (64-bit base, extension bits 8 and 18). The vendor (0xF11), architecture (0xF12), implementation (0xF13), hart (0xF14), both delegation (0x302, 0x303) and time (0xC01) registers read 0.
- R4: The status register (0x300) keeps interrupt enable at bit 3 and previous enable at bit 7, both writable. Bits 12:8 read 0x1D and all other bits read 0.
- R5: On `trap_en`, the previous-enable bit takes the enable bit and the enable bit clears. The exception PC takes `trap_pc`. The cause register (0x342) takes bit 63 = `trap_irq` and bits 3:0 = `trap_code`; only these bits are writable and the rest read 0.
- R6: On `mret_en` without `trap_en`, the enable bit takes the value of the previous-enable bit.
- R7: A trap in the same cycle as a software access or an MRET wins over both for every register that the trap updates.
- R8: Bit 11 of the pending register (0x344) follows `irq_pin` combinationally. All its bits are read-only.
- R9: In the enable register (0x304) only bit 11 is writable. `irq_req` is high exactly when that bit, the status enable bit and `irq_pin` are all high. It has no register stage.
- R10: An access (`csr_en` high) to any unlisted address raises `csr_illegal` in the same cycle, reads 0 and changes nothing.
- R11: The cycle counter (0xC00) increases by one on every clock edge out of reset.
- R12: The fetch counter (0xC02) increases by one on every clock edge at which `fetch_stb` is high.
- R13: `epc_out` always shows the exception PC register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| csr_en | input | 1 | Access valid this cycle |
| csr_addr | input | 12 | Register address |
| csr_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_wdata | input | 64 | Write data or bit mask |
| csr_rdata | output | 64 | Read data of the addressed register |
| csr_illegal | output | 1 | Access to an unimplemented address |
| trap_en | input | 1 | Trap entry strobe |
| trap_irq | input | 1 | Trap is an interrupt |
| trap_code | input | 4 | Trap cause code |
| trap_pc | input | 64 | PC to save on trap entry |
| mret_en | input | 1 | Return-from-trap strobe |
| irq_pin | input | 1 | External interrupt line |
| fetch_stb | input | 1 | One instruction fetched this cycle |
| trap_vector | output | 64 | Handler address |
| epc_out | output | 64 | Saved exception PC |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
A wrong enable or previous-enable bit shows up at `irq_req` within the same cycle that the pin rises. It also shows up in the status readback one cycle after a trap entry or a return. A slip in the cause or exception-PC capture can be seen at `epc_out` and at the cause readback on the first read after the trap edge. A wrong read-only mask or a wrong decode shows at once as wrong `csr_rdata` or a wrong `csr_illegal` during the access cycle. Counter faults appear as a wrong difference between two reads a known number of edges apart.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam int XLEN = 64;

  localparam logic [11:0] A_STATUS  = 12'h300;
  localparam logic [11:0] A_ISA     = 12'h301;
  localparam logic [11:0] A_EDELEG  = 12'h302;
  localparam logic [11:0] A_IDELEG  = 12'h303;
  localparam logic [11:0] A_IE      = 12'h304;
  localparam logic [11:0] A_TVEC    = 12'h305;
  localparam logic [11:0] A_SCRATCH = 12'h340;
  localparam logic [11:0] A_EPC     = 12'h341;
  localparam logic [11:0] A_CAUSE   = 12'h342;
  localparam logic [11:0] A_BADADDR = 12'h343;
  localparam logic [11:0] A_IP      = 12'h344;
  localparam logic [11:0] A_CYCLE   = 12'hC00;
  localparam logic [11:0] A_TIME    = 12'hC01;
  localparam logic [11:0] A_INSTRET = 12'hC02;
  localparam logic [11:0] A_VENDOR  = 12'hF11;
  localparam logic [11:0] A_ARCH    = 12'hF12;
  localparam logic [11:0] A_IMPL    = 12'hF13;
  localparam logic [11:0] A_HART    = 12'hF14;

  localparam int          EXT_IRQ_BIT = 11;
  localparam int          IE_BIT      = 3;
  localparam int          PIE_BIT     = 7;
  localparam logic [4:0]  PREV_PRIV   = 5'h1D;
  localparam logic [XLEN-1:0] ISA_VAL = {2'b10, 36'd0, 26'h0040100};

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  typedef struct packed {
    logic status;
    logic isa;
    logic zero_ro;
    logic ie;
    logic tvec;
    logic scratch;
    logic epc;
    logic cause;
    logic badaddr;
    logic ip;
    logic cycle;
    logic instret;
  } csr_sel_t;

  function automatic logic [XLEN-1:0] csr_apply(input logic [XLEN-1:0] cur,
                                                input logic [XLEN-1:0] wd,
                                                input csr_op_e op);
    logic [XLEN-1:0] r;
    case (op)
      OP_WRITE: r = wd;
      OP_SET:   r = cur | wd;
      OP_CLEAR: r = cur & ~wd;
      default:  r = cur;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
  import mcsr_pkg::*;
(
  input  logic        csr_en,
  input  logic [11:0] csr_addr,
  output csr_sel_t    sel,
  output logic        illegal
);
  always_comb begin
    sel = '0;
    case (csr_addr)
      A_STATUS:  sel.status  = 1'b1;
      A_ISA:     sel.isa     = 1'b1;
      A_EDELEG, A_IDELEG, A_TIME,
      A_VENDOR, A_ARCH, A_IMPL, A_HART:
                 sel.zero_ro = 1'b1;
      A_IE:      sel.ie      = 1'b1;
      A_TVEC:    sel.tvec    = 1'b1;
      A_SCRATCH: sel.scratch = 1'b1;
      A_EPC:     sel.epc     = 1'b1;
      A_CAUSE:   sel.cause   = 1'b1;
      A_BADADDR: sel.badaddr = 1'b1;
      A_IP:      sel.ip      = 1'b1;
      A_CYCLE:   sel.cycle   = 1'b1;
      A_INSTRET: sel.instret = 1'b1;
      default:   sel = '0;
    endcase
    illegal = csr_en && (sel == '0);
  end
endmodule

// File: rtl/mcsr_trap_regs.sv
module mcsr_trap_regs
  import mcsr_pkg::*;
#(
  parameter logic [XLEN-1:0] TVEC_RST = 64'hFFFF_FFFF_FFFF_FE00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_status,
  input  logic            wr_ie,
  input  logic            wr_tvec,
  input  logic            wr_scratch,
  input  logic            wr_epc,
  input  logic            wr_cause,
  input  logic            wr_badaddr,
  input  logic [XLEN-1:0] wr_val,
  input  logic            trap_en,
  input  logic            trap_irq,
  input  logic [3:0]      trap_code,
  input  logic [XLEN-1:0] trap_pc,
  input  logic            mret_en,
  output logic            st_mie,
  output logic            st_mpie,
  output logic            ext_ie,
  output logic [XLEN-1:0] tvec,
  output logic [XLEN-1:0] scratch,
  output logic [XLEN-1:0] epc,
  output logic            cause_irq,
  output logic [3:0]      cause_code,
  output logic [XLEN-1:0] badaddr
);
  logic            mie_d, mpie_d, status_ce;
  logic            cause_irq_d, cause_ce;
  logic [3:0]      cause_code_d;
  logic [XLEN-1:0] epc_d;
  logic            epc_ce;

  // Status next state: trap beats return beats software access.
  always_comb begin
    mie_d     = st_mie;
    mpie_d    = st_mpie;
    status_ce = 1'b0;
    if (trap_en) begin
      mpie_d    = st_mie;
      mie_d     = 1'b0;
      status_ce = 1'b1;
    end else if (mret_en) begin
      mie_d     = st_mpie;
      status_ce = 1'b1;
    end else if (wr_status) begin
      mie_d     = wr_val[IE_BIT];
      mpie_d    = wr_val[PIE_BIT];
      status_ce = 1'b1;
    end
  end

  always_comb begin
    cause_irq_d  = cause_irq;
    cause_code_d = cause_code;
    cause_ce     = 1'b0;
    epc_d        = epc;
    epc_ce       = 1'b0;
    if (trap_en) begin
      cause_irq_d  = trap_irq;
      cause_code_d = trap_code;
      cause_ce     = 1'b1;
      epc_d        = trap_pc;
      epc_ce       = 1'b1;
    end else begin
      if (wr_cause) begin
        cause_irq_d  = wr_val[XLEN-1];
        cause_code_d = wr_val[3:0];
        cause_ce     = 1'b1;
      end
      if (wr_epc) begin
        epc_d  = wr_val;
        epc_ce = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_mie  <= 1'b0;
      st_mpie <= 1'b0;
    end else if (status_ce) begin
      st_mie  <= mie_d;
      st_mpie <= mpie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_irq  <= 1'b0;
      cause_code <= 4'd0;
    end else if (cause_ce) begin
      cause_irq  <= cause_irq_d;
      cause_code <= cause_code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      epc <= '0;
    else if (epc_ce) epc <= epc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ext_ie <= 1'b0;
    else if (wr_ie) ext_ie <= wr_val[EXT_IRQ_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tvec <= TVEC_RST;
    else if (wr_tvec) tvec <= wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          scratch <= '0;
    else if (wr_scratch) scratch <= wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          badaddr <= '0;
    else if (wr_badaddr) badaddr <= wr_val;
  end
endmodule

// File: rtl/mcsr_counters.sv
module mcsr_counters #(
  parameter int CNT_W  = 64,
  parameter int NUM_CT = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CT-1:0]            inc,
  output logic [NUM_CT-1:0][CNT_W-1:0] count
);
  for (genvar g = 0; g < NUM_CT; g++) begin : g_ctr
    logic [CNT_W-1:0] nxt;
    always_comb nxt = count[g] + CNT_W'(1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count[g] <= '0;
      else if (inc[g]) count[g] <= nxt;
    end
  end
endmodule

// File: rtl/mcsr_bank.sv
module mcsr_bank
  import mcsr_pkg::*;
#(
  parameter logic [XLEN-1:0] TVEC_RST = 64'hFFFF_FFFF_FFFF_FE00,
  parameter int              CNT_W    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_en,
  input  logic [11:0]      csr_addr,
  input  logic [1:0]       csr_op,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  csr_rdata,
  output logic             csr_illegal,
  input  logic             trap_en,
  input  logic             trap_irq,
  input  logic [3:0]       trap_code,
  input  logic [XLEN-1:0]  trap_pc,
  input  logic             mret_en,
  input  logic             irq_pin,
  input  logic             fetch_stb,
  output logic [XLEN-1:0]  trap_vector,
  output logic [XLEN-1:0]  epc_out,
  output logic             irq_req
);
  localparam int CT_CYCLE   = 0;
  localparam int CT_INSTRET = 1;

  csr_sel_t        sel;
  logic            wr_any;
  logic [XLEN-1:0] wr_val;
  logic            st_mie, st_mpie, ext_ie, cause_irq;
  logic [3:0]      cause_code;
  logic [XLEN-1:0] tvec, scratch, epc, badaddr;
  logic [1:0][CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_cycle, cnt_instret;

  mcsr_decode u_dec (
    .csr_en   (csr_en),
    .csr_addr (csr_addr),
    .sel      (sel),
    .illegal  (csr_illegal)
  );

  // Read mux: only implemented bits are driven, the rest read zero.
  always_comb begin
    csr_rdata = '0;
    if (sel.status) begin
      csr_rdata[12:8]    = PREV_PRIV;
      csr_rdata[PIE_BIT] = st_mpie;
      csr_rdata[IE_BIT]  = st_mie;
    end
    if (sel.isa)     csr_rdata = ISA_VAL;
    if (sel.ie)      csr_rdata[EXT_IRQ_BIT] = ext_ie;
    if (sel.ip)      csr_rdata[EXT_IRQ_BIT] = irq_pin;
    if (sel.tvec)    csr_rdata = tvec;
    if (sel.scratch) csr_rdata = scratch;
    if (sel.epc)     csr_rdata = epc;
    if (sel.cause) begin
      csr_rdata[XLEN-1] = cause_irq;
      csr_rdata[3:0]    = cause_code;
    end
    if (sel.badaddr) csr_rdata = badaddr;
    if (sel.cycle)   csr_rdata = XLEN'(cnt_cycle);
    if (sel.instret) csr_rdata = XLEN'(cnt_instret);
  end

  always_comb begin
    wr_any = csr_en && !csr_illegal && (csr_op != 2'd0);
    wr_val = csr_apply(csr_rdata, csr_wdata, csr_op_e'(csr_op));
  end

  mcsr_trap_regs #(.TVEC_RST(TVEC_RST)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_status  (wr_any && sel.status),
    .wr_ie      (wr_any && sel.ie),
    .wr_tvec    (wr_any && sel.tvec),
    .wr_scratch (wr_any && sel.scratch),
    .wr_epc     (wr_any && sel.epc),
    .wr_cause   (wr_any && sel.cause),
    .wr_badaddr (wr_any && sel.badaddr),
    .wr_val     (wr_val),
    .trap_en    (trap_en),
    .trap_irq   (trap_irq),
    .trap_code  (trap_code),
    .trap_pc    (trap_pc),
    .mret_en    (mret_en),
    .st_mie     (st_mie),
    .st_mpie    (st_mpie),
    .ext_ie     (ext_ie),
    .tvec       (tvec),
    .scratch    (scratch),
    .epc        (epc),
    .cause_irq  (cause_irq),
    .cause_code (cause_code),
    .badaddr    (badaddr)
  );

  mcsr_counters #(.CNT_W(CNT_W), .NUM_CT(2)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   ({fetch_stb, 1'b1}),
    .count (cnt)
  );

  always_comb begin
    cnt_cycle   = cnt[CT_CYCLE];
    cnt_instret = cnt[CT_INSTRET];
    trap_vector = tvec;
    epc_out     = epc;
    irq_req     = st_mie && ext_ie && irq_pin;
  end
endmodule

// File: rtl/mcsr_bank_chk.sv
module mcsr_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        csr_en,
  input logic [11:0] csr_addr,
  input logic [1:0]  csr_op,
  input logic        csr_illegal,
  input logic [63:0] csr_rdata,
  input logic        trap_en,
  input logic [63:0] trap_pc,
  input logic        mret_en,
  input logic        irq_pin,
  input logic        irq_req,
  input logic [63:0] trap_vector,
  input logic [63:0] epc_out,
  input logic        st_mie,
  input logic        st_mpie,
  input logic [63:0] cnt_cycle
);
  // R10
  illegal_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (csr_rdata == 64'd0));

  // R10
  illegal_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> csr_en);

  // R5
  trap_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_en |=> (epc_out == $past(trap_pc)));

  // R5
  trap_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_en |=> (!st_mie && (st_mpie == $past(st_mie))));

  // R6
  mret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_en && !trap_en) |=> (st_mie == $past(st_mpie)));

  // R9
  irq_needs_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_pin && st_mie));

  // R11
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cnt_cycle == $past(cnt_cycle) + 64'd1));

  // R2
  tvec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_en && csr_addr == 12'h305 && csr_op != 2'd0) |=> $stable(trap_vector));
endmodule

bind mcsr_bank mcsr_bank_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csr_en      (csr_en),
  .csr_addr    (csr_addr),
  .csr_op      (csr_op),
  .csr_illegal (csr_illegal),
  .csr_rdata   (csr_rdata),
  .trap_en     (trap_en),
  .trap_pc     (trap_pc),
  .mret_en     (mret_en),
  .irq_pin     (irq_pin),
  .irq_req     (irq_req),
  .trap_vector (trap_vector),
  .epc_out     (epc_out),
  .st_mie      (st_mie),
  .st_mpie     (st_mpie),
  .cnt_cycle   (cnt_cycle)
);

// File: tb/mcsr_bank_test.sv
module mcsr_bank_test;
  logic        clk, rst_n, csr_en, csr_illegal, trap_en, trap_irq, mret_en, irq_pin, fetch_stb, irq_req;
  logic [11:0] csr_addr;
  logic [1:0]  csr_op;
  logic [63:0] csr_wdata, csr_rdata, trap_pc, trap_vector, epc_out;
  logic [3:0]  trap_code;
  int errs = 0, checks = 0;
  bit done = 0;

  mcsr_bank uut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [11:0] a;
    logic [1:0]  op;
    logic [63:0] d;
    logic [63:0] e;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{12'h340, 2'd1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0},
    '{12'h340, 2'd2, 64'h0000_0000_0000_000F, 64'h1234_5678_9ABC_DEFF},
    '{12'h340, 2'd3, 64'h0000_0000_0000_00F0, 64'h1234_5678_9ABC_DE0F},
    '{12'h300, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_1D88},
    '{12'h300, 2'd3, 64'h0000_0000_0000_0008, 64'h0000_0000_0000_1D80},
    '{12'h304, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0800},
    '{12'h301, 2'd1, 64'h0000_0000_0000_0000, 64'h8000_0000_0004_0100},
    '{12'h342, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_000F},
    '{12'h305, 2'd1, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000},
    '{12'h343, 2'd2, 64'hDEAD_0000_0000_BEEF, 64'hDEAD_0000_0000_BEEF},
    '{12'hF14, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000},
    '{12'h302, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [11:0] a, input logic [1:0] op, input logic [63:0] d);
    csr_en = 1'b1; csr_addr = a; csr_op = op; csr_wdata = d;
    @(negedge clk);
    csr_en = 1'b0; csr_op = 2'd0; csr_wdata = '0;
  endtask

  task automatic csr_rd(input logic [11:0] a, output logic [63:0] rd, output logic ill);
    csr_en = 1'b1; csr_addr = a; csr_op = 2'd0;
    #2;
    rd = csr_rdata; ill = csr_illegal;
    @(negedge clk);
    csr_en = 1'b0;
  endtask

  task automatic do_trap(input logic irq, input logic [3:0] code, input logic [63:0] pc);
    trap_en = 1'b1; trap_irq = irq; trap_code = code; trap_pc = pc;
    @(negedge clk);
    trap_en = 1'b0; trap_irq = 1'b0; trap_code = '0; trap_pc = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd, c0, c1;
    logic ill;
    rst_n = 1'b0; csr_en = 0; csr_addr = '0; csr_op = '0; csr_wdata = '0;
    trap_en = 0; trap_irq = 0; trap_code = '0; trap_pc = '0; mret_en = 0;
    irq_pin = 0; fetch_stb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 trap_vector", trap_vector, 64'hFFFF_FFFF_FFFF_FE00);
    check("R1 epc_out", epc_out, 64'd0);
    csr_rd(12'h305, rd, ill); check("R1 tvec", rd, 64'hFFFF_FFFF_FFFF_FE00);
    csr_rd(12'h300, rd, ill); check("R1 status", rd, 64'h1D00);
    csr_rd(12'h342, rd, ill); check("R1 cause", rd, 64'd0);
    csr_rd(12'h304, rd, ill); check("R1 ie", rd, 64'd0);
    csr_rd(12'h340, rd, ill); check("R1 scratch", rd, 64'd0);

    // R2 R3 R4 vector walk
    for (int i = 0; i < 12; i++) begin
      csr_wr(VECS[i].a, VECS[i].op, VECS[i].d);
      csr_rd(VECS[i].a, rd, ill);
      check("R2/R3/R4 vector", rd, VECS[i].e);
      check("R10 legal flag", {63'd0, ill}, 64'd0);
    end
    check("R2 trap_vector port", trap_vector, 64'h0000_0000_8000_0000);

    // R10 unimplemented address
    csr_rd(12'h7C0, rd, ill);
    check("R10 illegal flag", {63'd0, ill}, 64'd1);
    check("R10 illegal data", rd, 64'd0);
    csr_wr(12'h7C0, 2'd1, 64'h55);
    csr_rd(12'h340, rd, ill); check("R10 no side effect", rd, 64'h1234_5678_9ABC_DE0F);

    // R5 trap entry with enable set
    csr_wr(12'h300, 2'd1, 64'h8);
    do_trap(1'b0, 4'd3, 64'h1000);
    check("R13 epc_out", epc_out, 64'h1000);
    csr_rd(12'h300, rd, ill); check("R5 status after trap", rd, 64'h1D80);
    csr_rd(12'h342, rd, ill); check("R5 cause", rd, 64'd3);
    csr_rd(12'h341, rd, ill); check("R5 epc", rd, 64'h1000);

    // R6 return
    mret_en = 1'b1; @(negedge clk); mret_en = 1'b0;
    csr_rd(12'h300, rd, ill); check("R6 status after mret", rd, 64'h1D88);

    // R7 trap with simultaneous writes
    csr_en = 1'b1; csr_addr = 12'h341; csr_op = 2'd1; csr_wdata = 64'hBAD0;
    trap_en = 1'b1; trap_irq = 1'b1; trap_code = 4'd11; trap_pc = 64'h2000;
    @(negedge clk);
    csr_en = 1'b0; csr_op = 2'd0; trap_en = 1'b0; trap_irq = 1'b0; trap_code = '0;
    csr_rd(12'h341, rd, ill); check("R7 epc trap wins", rd, 64'h2000);
    csr_rd(12'h342, rd, ill); check("R7 irq cause", rd, 64'h8000_0000_0000_000B);
    csr_en = 1'b1; csr_addr = 12'h300; csr_op = 2'd1; csr_wdata = 64'h88;
    trap_en = 1'b1; mret_en = 1'b1; trap_pc = 64'h3000;
    @(negedge clk);
    csr_en = 1'b0; csr_op = 2'd0; trap_en = 1'b0; mret_en = 1'b0;
    csr_rd(12'h300, rd, ill); check("R7 status trap wins", rd, 64'h1D00);

    // R8 R9 interrupt path (ie bit 11 still set from the walk)
    irq_pin = 1'b1; #2;
    check("R9 no req while disabled", {63'd0, irq_req}, 64'd0);
    csr_rd(12'h344, rd, ill); check("R8 pending high", rd, 64'h800);
    csr_wr(12'h300, 2'd2, 64'h8); #2;
    check("R9 req", {63'd0, irq_req}, 64'd1);
    irq_pin = 1'b0; #2;
    check("R9 req drops", {63'd0, irq_req}, 64'd0);
    csr_rd(12'h344, rd, ill); check("R8 pending low", rd, 64'd0);
    csr_wr(12'h344, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    csr_rd(12'h344, rd, ill); check("R8 pending read-only", rd, 64'd0);
    csr_wr(12'h304, 2'd3, 64'h800); irq_pin = 1'b1; #2;
    check("R9 ie cleared", {63'd0, irq_req}, 64'd0);
    irq_pin = 1'b0;

    // R11 cycle counter
    csr_rd(12'hC00, c0, ill);
    repeat (9) @(negedge clk);
    csr_rd(12'hC00, c1, ill);
    check("R11 cycle delta", c1 - c0, 64'd10);

    // R12 fetch counter
    csr_rd(12'hC02, c0, ill);
    check("R12 no fetch yet", c0, 64'd0);
    fetch_stb = 1'b1; repeat (5) @(negedge clk); fetch_stb = 1'b0;
    repeat (2) @(negedge clk);
    csr_rd(12'hC02, c1, ill);
    check("R12 fetch delta", c1 - c0, 64'd5);

    // R3 time reads zero
    csr_rd(12'hC01, rd, ill); check("R3 time zero", rd, 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule